// File: doc/BRIEF.md
# HDLC Receive Deframer With In-Band Escaping

This block sits behind a bit-level demodulator. It takes a serial stream of recovered bits, each marked by a one-cycle valid strobe, and turns it into a byte stream on a valid/ready output. It keeps a short history of the incoming bits and uses it to find frame delimiters, to detect aborts and to drop the zero bits that a sender inserts after runs of ones. The remaining data bits are packed into bytes, least significant bit first.

Frame boundaries are not reported on sideband pins. Each delimiter is placed in the byte stream as the value 0x7E. Any data byte that collides with one of the three control values (0x7E delimiter, 0x7F abort, 0x1B escape) is sent with a 0x1B escape byte in front of it. A consumer can therefore split frames from a single byte lane. A small output FIFO absorbs backpressure. An escape byte and the data byte it protects are written to the FIFO together or not at all.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the output is empty (out_valid low) and receiving is disabled, so bits that arrive before the first delimiter produce no output.
- R2: When the newest eight bits, newest in bit 0, read 0x7E, a single 0x7E byte is emitted, receiving is enabled, and any partially built byte is discarded so the next data bit starts a new byte.
- R3: When the low seven bits of the history are all ones (history & 0x7F == 0x7F), receiving is disabled until the next delimiter.
- R4: While receiving, a bit that makes the low six history bits equal 0x3E (a zero after five ones) is dropped as a stuffed bit.
- R5: While receiving, every eight kept data bits form one byte. The first bit received is bit 0 of that byte.
- R6: A completed byte equal to 0x7E, 0x7F or 0x1B is emitted as 0x1B followed by the byte. Every other byte is emitted alone.
- R7: Bits that arrive while receiving is disabled change only the bit history and produce no output.
- R8: Bytes leave in the order they were produced. While out_valid is high and out_ready is low, out_data stays unchanged.
- R9: An output item (one byte, or an escape plus data pair) is written only if the FIFO's free space, counted before any read in the same cycle, is at least the item's size. Otherwise the whole item is dropped.
- R10: A byte written into an empty FIFO appears on out_valid in the cycle after the clock edge that accepted the completing bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: bit_in carries a new bit this cycle |
| bit_in | input | 1 | Recovered serial bit |
| out_ready | input | 1 | Consumer accepts out_data this cycle |
| out_valid | output | 1 | out_data holds a byte |
| out_data | output | 8 | Output byte (data, 0x7E delimiter or 0x1B escape) |

## Verification
A history register or receive-enable flag that goes wrong shows up within one bit time. A delimiter would go missing, or data would leak out after an abort, and either error reaches out_valid one cycle after the offending bit. A byte counter or assembler that slips by one bit corrupts the next byte, which appears at most eight bits later as a wrong value. A realignment after a delimiter therefore catches slips left over from an aborted frame. FIFO level errors show up as a split escape pair, a lost byte or a byte that changes while stalled. The bench brings these out by stalling the consumer until the FIFO has exactly one free slot and then sending a pair.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int BCNT_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_CODE = 8'h7F;
  localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h1B;
  localparam logic [5:0]        STUFF_PAT  = 6'h3E;

  // a byte that must be preceded by an escape in the output lane
  function automatic logic is_ctrl(input logic [BYTE_W-1:0] b);
    return (b == FLAG_CODE) || (b == ABORT_CODE) || (b == ESC_CODE);
  endfunction

  // seven ones at the young end of the history
  function automatic logic is_abort(input logic [BYTE_W-1:0] h);
    return (h & ABORT_CODE) == ABORT_CODE;
  endfunction

  // zero directly after five ones
  function automatic logic is_stuffed(input logic [BYTE_W-1:0] h);
    return h[5:0] == STUFF_PAT;
  endfunction
endpackage

// File: rtl/hdlc_bit_tracker.sv
module hdlc_bit_tracker
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic flag_hit,
  output logic abort_hit,
  output logic stuff_hit,
  output logic data_take,
  output logic rx_en
);
  logic [BYTE_W-1:0] hist_q;
  logic [BYTE_W-1:0] hist_n;
  logic              rx_en_q;

  assign hist_n    = {hist_q[BYTE_W-2:0], bit_in};
  assign flag_hit  = bit_valid && (hist_n == FLAG_CODE);
  assign abort_hit = bit_valid && !flag_hit && is_abort(hist_n);
  assign stuff_hit = bit_valid && rx_en_q && !flag_hit && !abort_hit && is_stuffed(hist_n);
  assign data_take = bit_valid && rx_en_q && !flag_hit && !abort_hit && !stuff_hit;
  assign rx_en     = rx_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q  <= '0;
      rx_en_q <= 1'b0;
    end else if (bit_valid) begin
      hist_q <= hist_n;
      if (flag_hit)       rx_en_q <= 1'b1;
      else if (abort_hit) rx_en_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_byte_asm.sv
module hdlc_byte_asm
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_hit,
  input  logic              data_take,
  input  logic              bit_in,
  output logic [1:0]        push_n,
  output logic [BYTE_W-1:0] push_d0,
  output logic [BYTE_W-1:0] push_d1
);
  logic [BYTE_W-1:0] asm_q;
  logic [BCNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] shifted;
  logic              byte_done;

  assign shifted   = {bit_in, asm_q[BYTE_W-1:1]};
  assign byte_done = data_take && (cnt_q == BCNT_W'(BYTE_W - 1));

  always_comb begin
    push_n  = 2'd0;
    push_d0 = '0;
    push_d1 = '0;
    if (flag_hit) begin
      push_n  = 2'd1;
      push_d0 = FLAG_CODE;
    end else if (byte_done && is_ctrl(shifted)) begin
      push_n  = 2'd2;
      push_d0 = ESC_CODE;
      push_d1 = shifted;
    end else if (byte_done) begin
      push_n  = 2'd1;
      push_d0 = shifted;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flag_hit) begin
      asm_q <= '0;
      cnt_q <= '0;
    end else if (byte_done) begin
      asm_q <= '0;
      cnt_q <= '0;
    end else if (data_take) begin
      asm_q <= shifted;
      cnt_q <= cnt_q + BCNT_W'(1);
    end
  end
endmodule

// File: rtl/hdlc_out_fifo.sv
module hdlc_out_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 push_n,
  input  logic [BYTE_W-1:0]          push_d0,
  input  logic [BYTE_W-1:0]          push_d1,
  input  logic                       rd_ready,
  output logic                       rd_valid,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       wr_ok
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic [LVL_W-1:0]  free_slots;
  logic              rd_fire;

  assign free_slots = LVL_W'(DEPTH) - level_q;
  assign wr_ok      = (push_n != 2'd0) && (LVL_W'(push_n) <= free_slots);
  assign rd_valid   = (level_q != '0);
  assign rd_fire    = rd_valid && rd_ready;
  assign rd_data    = mem[rd_ptr_q];
  assign level      = level_q;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_ptr_q] <= push_d0;
      if (push_n == 2'd2) mem[wr_ptr_q + PTR_W'(1)] <= push_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (wr_ok)   wr_ptr_q <= wr_ptr_q + PTR_W'(push_n);
      if (rd_fire) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      level_q <= level_q + (wr_ok ? LVL_W'(push_n) : LVL_W'(0)) - LVL_W'(rd_fire);
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data
);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);

  logic              flag_hit, abort_hit, stuff_hit, data_take, rx_en;
  logic [1:0]        push_n;
  logic [BYTE_W-1:0] push_d0, push_d1;
  logic [LVL_W-1:0]  fifo_level;
  logic              wr_ok;

  hdlc_bit_tracker u_track (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .flag_hit(flag_hit), .abort_hit(abort_hit), .stuff_hit(stuff_hit),
    .data_take(data_take), .rx_en(rx_en)
  );

  hdlc_byte_asm u_asm (
    .clk(clk), .rst_n(rst_n), .flag_hit(flag_hit), .data_take(data_take),
    .bit_in(bit_in), .push_n(push_n), .push_d0(push_d0), .push_d1(push_d1)
  );

  hdlc_out_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_d0(push_d0),
    .push_d1(push_d1), .rd_ready(out_ready), .rd_valid(out_valid),
    .rd_data(out_data), .level(fifo_level), .wr_ok(wr_ok)
  );
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             flag_hit,
  input logic             abort_hit,
  input logic             stuff_hit,
  input logic             rx_en,
  input logic [1:0]       push_n,
  input logic [7:0]       push_d0,
  input logic             wr_ok,
  input logic [LVL_W-1:0] fifo_level
);
  assert_flag_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hit |=> rx_en);

  assert_abort_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> !rx_en);

  assert_stuff_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_hit |-> push_n == 2'd0);

  assert_pair_led_by_escape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_n == 2'd2 |-> push_d0 == 8'h1B);

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !rx_en && !flag_hit) |-> push_n == 2'd0);

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_write_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> out_valid);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .flag_hit(flag_hit),
  .abort_hit(abort_hit), .stuff_hit(stuff_hit), .rx_en(rx_en),
  .push_n(push_n), .push_d0(push_d0), .wr_ok(wr_ok), .fifo_level(fifo_level)
);

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int ones = 0;
  int cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  hdlc_rx_deframer #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  // scoreboard monitor: the transfer happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R8: actual %02h expected no byte", out_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
  end

  // expected items follow the space rule of R9 (space before same-cycle read)
  task automatic send_bit(input logic b, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input string tag);
    @(posedge clk); #1;
    bit_valid = 1'b1;
    bit_in = b;
    if (n > 0 && n <= DEPTH - exp_q.size()) begin
      exp_q.push_back(d0); tag_q.push_back(tag);
      if (n == 2) begin exp_q.push_back(d1); tag_q.push_back(tag); end
    end
    @(posedge clk); #1;
    bit_valid = 1'b0;
  endtask

  task automatic send_flag(input string tag);
    for (int i = 0; i < 8; i++)
      send_bit(((8'h7E >> i) & 8'h01) != 0, (i == 7) ? 1 : 0, 8'h7E, 8'h00, tag);
    ones = 0;
  endtask

  // sender side: LSB first with a zero inserted after five ones
  task automatic send_data(input logic [7:0] v, input string tag);
    logic ctl;
    ctl = (v == 8'h7E) || (v == 8'h7F) || (v == 8'h1B);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) send_bit(v[i], ctl ? 2 : 1, ctl ? 8'h1B : v, v, tag);
      else        send_bit(v[i], 0, 8'h00, 8'h00, tag);
      ones = v[i] ? ones + 1 : 0;
      if (ones == 5) begin
        send_bit(1'b0, 0, 8'h00, 8'h00, tag);
        ones = 0;
      end
    end
  endtask

  task automatic drain_and_check_idle(input string tag);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    check(out_valid == 1'b0, tag, out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R1 reset empty", out_valid, 0);

    // R1: no output before the first delimiter
    send_bit(1, 0, 0, 0, "R1"); send_bit(0, 0, 0, 0, "R1");
    send_bit(1, 0, 0, 0, "R1"); send_bit(0, 0, 0, 0, "R1");
    send_bit(0, 0, 0, 0, "R1"); send_bit(1, 0, 0, 0, "R1");
    drain_and_check_idle("R1 pre-flag bits");

    // R2 / R10: delimiter byte visible one cycle after the last bit edge
    send_flag("R2 flag");
    check(out_valid == 1'b1, "R10 latency", out_valid, 1);

    // R5: plain bytes, LSB first; R4: stuffing on runs of ones
    send_data(8'h41, "R5 byte 41");
    send_data(8'hA5, "R5 byte A5");
    send_data(8'h00, "R5 byte 00");
    send_data(8'hFF, "R4 stuffed FF");
    send_data(8'hF8, "R4 stuffed F8");
    // R6: control collisions escaped
    send_data(8'h7E, "R6 escape 7E");
    send_data(8'h7F, "R6 escape 7F");
    send_data(8'h1B, "R6 escape 1B");
    send_data(8'h1C, "R6 plain 1C");
    send_flag("R2 closing flag");
    drain_and_check_idle("R8 order");

    // R3: abort mid-frame. Bits 1,0,0 plus five ones complete 0xF9,
    // the sixth one starts a partial byte, the seventh one aborts.
    send_flag("R2 reopen");
    send_bit(1, 0, 0, 0, "R3"); send_bit(0, 0, 0, 0, "R3"); send_bit(0, 0, 0, 0, "R3");
    for (int i = 0; i < 5; i++)
      send_bit(1, (i == 4) ? 1 : 0, 8'hF9, 8'h00, "R3 byte before abort");
    send_bit(1, 0, 0, 0, "R3"); send_bit(1, 0, 0, 0, "R3");
    // R7: bits while disabled give no output
    for (int i = 0; i < 16; i++) send_bit((i % 3) == 1, 0, 0, 0, "R7");
    drain_and_check_idle("R7 disabled after abort R3");

    // R2: the delimiter re-enables and realigns the partial byte
    send_flag("R2 flag after abort");
    send_data(8'h5A, "R2 realigned 5A");
    drain_and_check_idle("R2 realign");

    // R9: stall until one slot is free, then send a pair
    @(posedge clk); #1 out_ready = 1'b0;
    send_flag("R9 flag");
    send_data(8'h41, "R9 first");
    send_data(8'h42, "R9 second");
    send_data(8'h7F, "R9 pair dropped");
    send_data(8'h43, "R9 single fits");
    check(out_data == 8'h7E, "R8 head held", out_data, 8'h7E);
    repeat (5) @(posedge clk);
    #1;
    check(out_valid == 1'b1 && out_data == 8'h7E, "R8 stalled stable", out_data, 8'h7E);
    check(exp_q.size() == DEPTH, "R9 model level", exp_q.size(), DEPTH);
    out_ready = 1'b1;
    drain_and_check_idle("R9 drain");

    // recovery after a drop
    send_data(8'h1B, "R6 escape after drop");
    send_flag("R2 final flag");
    drain_and_check_idle("R8 final");

    report();
  end
endmodule